// File: doc/BRIEF.md
# Buffered Half-Duplex SPI Master

This block is a register-mapped SPI master meant for talking to serial flash and similar devices. Software loads a command word, a small outgoing data buffer and a length register, then starts a transaction. The engine shifts out up to 32 command bits and up to 256 write-data bits, then shifts in up to 256 read-data bits. Incoming bits overwrite the same data buffer, where software reads them back once the busy flag clears.

The transaction has three phases in a fixed order: command, then write data, then read data. Each phase has its own bit count and a count of zero skips it completely. Timing is SPI mode 0: SCK idles low, MOSI changes on falling edges, and MISO is sampled on rising edges. The SCK rate comes from a programmable divider of the system clock. Chip selects are driven straight from a software register, so one select can stay asserted across a chain of transactions, for example an opcode transaction followed by several read bursts.

The register bus is a plain 32-bit write strobe with a combinational read port. It never stalls, so there is no back-pressure at the block's edge. While a transaction runs, software polls the busy flag. Writes that arrive during that time are dropped by the rules below.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset the block is idle: SCK low, MOSI low, both chip-select outputs high, and the registers read back as zero.
- R2: Writing a word with bit 8 set to offset 0x00 while idle starts a transaction if the total bit count is nonzero. Bit 16 of offset 0x00 reads 1 from the next cycle until the last bit finishes. With all counts zero a start does nothing.
- R3: Bits [27:16] of the control register at 0x28 hold F. One SCK period is F+2 system clocks, with the low part first. SCK is low whenever the block is idle, and MOSI only changes while SCK is low.
- R4: The length register at 0x2C holds three counts. The command count is in [31:24] and is clamped to 32. The write count is in [8:0] and the read count is in [20:12], each clamped to 256. Exactly the clamped total of rising SCK edges is produced, in the order command, write, read.
- R5: With N command bits, command bit k (k counting from 0) is cmd[N-1-k], taken from the word at 0x04. The first byte therefore comes from the highest used byte lane.
- R6: Write-data byte j comes from bits [8(j%4)+7 : 8(j%4)] of the word at 0x08+4(j/4), sent MSB first by default. A phase with a zero count sends nothing, so the command word never leaks into a write-only transaction.
- R7: MOSI is low during the read phase. Read bit r is stored in byte r/8 of the buffer at 0x08 onward, using the same little-endian layout. The bit goes to position 7-(r%8) by default.
- R8: Bit 3 of 0x28 selects LSB-first order. It flips bit order within every byte: command position p becomes p with its three low bits inverted, and data bit r of a byte maps to position r%8.
- R9: A start written while busy is ignored. The running transaction keeps its length and no second transaction follows.
- R10: Writes to 0x04, 0x08-0x24, 0x28 and 0x2C while busy are discarded. They do not affect the running transaction and read back unchanged afterwards.
- R11: Bits [1:0] of 0x38 are the select enables. Output spi_cs_n[i] is the inverse of enable i, accepted at any time and untouched by transactions.
- R12: Every register reads back what was written while idle, and data words read back the buffer including received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
The hardest cases to reach from the ports are a second start and buffer, command and length writes that land in the middle of a running transaction. The bench starts a transaction with a slow divider and a long write phase. It waits a fixed number of cycles into the shift, then issues every forbidden write. A scoreboard then confirms that each remaining bit still comes from the original buffer contents and that no extra SCK edges appear. Clamping of oversized counts and the absence of command bits in a write-only transfer are also only visible as edge counts, so the scoreboard flags both surplus and missing edges.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W       = 6;
  localparam int CMD_MAX_BITS = 32;
  localparam int CNT_W        = 9;

  localparam logic [ADDR_W-1:0] OFS_XFER  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_LEN   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 6'h38;

  localparam int GO_BIT    = 8;
  localparam int BUSY_BIT  = 16;
  localparam int LSBF_BIT  = 3;
  localparam int DIV_LSB   = 16;
  localparam int LCMD_LSB  = 24;
  localparam int LRD_LSB   = 12;
  localparam int LWR_LSB   = 0;

  typedef struct packed {
    logic [5:0]       cmd;
    logic [CNT_W-1:0] wr;
    logic [CNT_W-1:0] rd;
  } spim_len_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int NUM_CS     = 2,
  parameter int DIV_W      = 12,
  parameter int DATA_WORDS = 8,
  parameter int DBIT_W     = $clog2(32 * DATA_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic                      busy,
  input  logic                      rx_we,
  input  logic [DBIT_W-1:0]         rx_pos,
  input  logic                      rx_bit,
  output logic                      start_req,
  output logic [31:0]               cmd_word,
  output logic [32*DATA_WORDS-1:0]  data_flat,
  output logic [DIV_W-1:0]          div_field,
  output logic                      lsb_first,
  output spim_len_t                 len,
  output logic [NUM_CS-1:0]         cs_en
);
  localparam int DATA_BITS = 32 * DATA_WORDS;

  logic [31:0]       cmd_q;
  logic [31:0]       data_q [DATA_WORDS];
  logic [DIV_W-1:0]  div_q;
  logic              lsbf_q;
  logic [7:0]        lcmd_q;
  logic [CNT_W-1:0]  lwr_q;
  logic [CNT_W-1:0]  lrd_q;
  logic [NUM_CS-1:0] sel_q;
  logic [DATA_WORDS-1:0] word_hit;
  logic              idle_we;

  assign idle_we = reg_we && !busy;

  for (genvar gi = 0; gi < DATA_WORDS; gi++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(8 + 4 * gi);
    assign word_hit[gi] = (reg_addr == WADDR);
    assign data_flat[32*gi +: 32] = data_q[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      div_q  <= '0;
      lsbf_q <= 1'b0;
      lcmd_q <= '0;
      lwr_q  <= '0;
      lrd_q  <= '0;
      for (int i = 0; i < DATA_WORDS; i++) data_q[i] <= '0;
    end else if (idle_we) begin
      if (reg_addr == OFS_CMD) cmd_q <= reg_wdata;
      if (reg_addr == OFS_CTRL) begin
        div_q  <= reg_wdata[DIV_LSB +: DIV_W];
        lsbf_q <= reg_wdata[LSBF_BIT];
      end
      if (reg_addr == OFS_LEN) begin
        lcmd_q <= reg_wdata[LCMD_LSB +: 8];
        lwr_q  <= reg_wdata[LWR_LSB +: CNT_W];
        lrd_q  <= reg_wdata[LRD_LSB +: CNT_W];
      end
      for (int i = 0; i < DATA_WORDS; i++)
        if (word_hit[i]) data_q[i] <= reg_wdata;
    end else if (rx_we) begin
      data_q[rx_pos[DBIT_W-1:5]][rx_pos[4:0]] <= rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sel_q <= '0;
    else if (reg_we && reg_addr == OFS_SEL) sel_q <= reg_wdata[NUM_CS-1:0];
  end

  assign start_req = reg_we && !busy && (reg_addr == OFS_XFER) && reg_wdata[GO_BIT];

  always_comb begin
    len.cmd = (lcmd_q > 8'(CMD_MAX_BITS)) ? 6'(CMD_MAX_BITS) : lcmd_q[5:0];
    len.wr  = (lwr_q > CNT_W'(DATA_BITS)) ? CNT_W'(DATA_BITS) : lwr_q;
    len.rd  = (lrd_q > CNT_W'(DATA_BITS)) ? CNT_W'(DATA_BITS) : lrd_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_XFER: reg_rdata[BUSY_BIT] = busy;
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_CTRL: begin
        reg_rdata[DIV_LSB +: DIV_W] = div_q;
        reg_rdata[LSBF_BIT]         = lsbf_q;
      end
      OFS_LEN: begin
        reg_rdata[LCMD_LSB +: 8]    = lcmd_q;
        reg_rdata[LWR_LSB +: CNT_W] = lwr_q;
        reg_rdata[LRD_LSB +: CNT_W] = lrd_q;
      end
      OFS_SEL:  reg_rdata[NUM_CS-1:0] = sel_q;
      default: begin
        for (int i = 0; i < DATA_WORDS; i++)
          if (word_hit[i]) reg_rdata = data_q[i];
      end
    endcase
  end

  assign cmd_word  = cmd_q;
  assign div_field = div_q;
  assign lsb_first = lsbf_q;
  assign cs_en     = sel_q;
endmodule

// File: rtl/spim_bitsel.sv
module spim_bitsel
  import spim_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int K_W        = 10,
  parameter int DBIT_W     = $clog2(32 * DATA_WORDS)
) (
  input  logic [K_W-1:0]            bit_idx,
  input  spim_len_t                 len,
  input  logic                      lsb_first,
  input  logic [31:0]               cmd_word,
  input  logic [32*DATA_WORDS-1:0]  data_flat,
  output logic                      tx_bit,
  output logic                      in_read,
  output logic [DBIT_W-1:0]         rx_pos
);
  logic [K_W-1:0]    c_end;
  logic [K_W-1:0]    w_end;
  logic [4:0]        cpos;
  logic [DBIT_W-1:0] k_wr;
  logic [DBIT_W-1:0] k_rd;
  logic [DBIT_W-1:0] wpos;

  always_comb begin
    c_end = K_W'(len.cmd);
    w_end = c_end + K_W'(len.wr);
    k_wr  = DBIT_W'(bit_idx - c_end);
    k_rd  = DBIT_W'(bit_idx - w_end);
    // command walks down from its top used bit
    cpos  = 5'(c_end - bit_idx - K_W'(1));
    if (lsb_first) cpos[2:0] = ~cpos[2:0];
    wpos   = {k_wr[DBIT_W-1:3], lsb_first ? k_wr[2:0] : ~k_wr[2:0]};
    rx_pos = {k_rd[DBIT_W-1:3], lsb_first ? k_rd[2:0] : ~k_rd[2:0]};
    in_read = (bit_idx >= w_end);
    if (bit_idx < c_end)  tx_bit = cmd_word[cpos];
    else if (!in_read)    tx_bit = data_flat[wpos];
    else                  tx_bit = 1'b0;
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DIV_W = 12,
  parameter int K_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [DIV_W-1:0] div_field,
  input  logic [K_W-1:0]   total_bits,
  input  logic             in_read,
  output logic             busy,
  output logic             sck,
  output logic [K_W-1:0]   bit_idx,
  output logic             rx_we
);
  localparam int P_W = DIV_W + 1;

  logic [P_W-1:0] period;
  logic [P_W-1:0] hi_len;
  logic [P_W-1:0] lo_len;
  logic [P_W-1:0] cnt_q;
  logic           busy_q;
  logic           sck_q;
  logic [K_W-1:0] k_q;
  logic           lo_done;
  logic           hi_done;

  assign period  = {1'b0, div_field} + P_W'(2);
  assign hi_len  = period >> 1;
  assign lo_len  = period - hi_len;
  assign lo_done = (cnt_q == lo_len - P_W'(1));
  assign hi_done = (cnt_q == hi_len - P_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      k_q    <= '0;
    end else if (!busy_q) begin
      if (start_req && total_bits != '0) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        cnt_q  <= '0;
        k_q    <= '0;
      end
    end else if (!sck_q) begin
      if (lo_done) begin
        sck_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + P_W'(1);
      end
    end else begin
      if (hi_done) begin
        sck_q <= 1'b0;
        cnt_q <= '0;
        if (k_q == total_bits - K_W'(1)) busy_q <= 1'b0;
        else                             k_q    <= k_q + K_W'(1);
      end else begin
        cnt_q <= cnt_q + P_W'(1);
      end
    end
  end

  assign rx_we   = busy_q && !sck_q && lo_done && in_read;
  assign busy    = busy_q;
  assign sck     = sck_q;
  assign bit_idx = k_q;
endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
  import spim_pkg::*;
#(
  parameter int NUM_CS     = 2,
  parameter int DIV_W      = 12,
  parameter int DATA_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int DATA_BITS = 32 * DATA_WORDS;
  localparam int DBIT_W    = $clog2(DATA_BITS);
  localparam int K_W       = $clog2(CMD_MAX_BITS + 2 * DATA_BITS + 1);

  logic                     busy;
  logic                     start_req;
  logic                     rx_we;
  logic [DBIT_W-1:0]        rx_pos;
  logic [31:0]              cmd_word;
  logic [DATA_BITS-1:0]     data_flat;
  logic [DIV_W-1:0]         div_field;
  logic                     lsb_first;
  spim_len_t                len;
  logic [NUM_CS-1:0]        cs_en;
  logic [K_W-1:0]           total_bits;
  logic [K_W-1:0]           bit_idx;
  logic                     tx_bit;
  logic                     in_read;

  assign total_bits = K_W'(len.cmd) + K_W'(len.wr) + K_W'(len.rd);

  spim_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .DATA_WORDS(DATA_WORDS), .DBIT_W(DBIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(spi_miso),
    .start_req(start_req), .cmd_word(cmd_word), .data_flat(data_flat),
    .div_field(div_field), .lsb_first(lsb_first), .len(len), .cs_en(cs_en)
  );

  spim_bitsel #(.DATA_WORDS(DATA_WORDS), .K_W(K_W), .DBIT_W(DBIT_W)) u_bitsel (
    .bit_idx(bit_idx), .len(len), .lsb_first(lsb_first), .cmd_word(cmd_word),
    .data_flat(data_flat), .tx_bit(tx_bit), .in_read(in_read), .rx_pos(rx_pos)
  );

  spim_engine #(.DIV_W(DIV_W), .K_W(K_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .div_field(div_field),
    .total_bits(total_bits), .in_read(in_read), .busy(busy), .sck(spi_sck),
    .bit_idx(bit_idx), .rx_we(rx_we)
  );

  assign spi_mosi = busy && tx_bit;
  assign spi_cs_n = ~cs_en;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NUM_CS = 2,
  parameter int K_W    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic              reg_we,
  input logic [5:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       cmd_word,
  input logic [K_W-1:0]    total_bits
);
  // R3
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  // R3
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R2
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 6'h00 && reg_wdata[8] && total_bits != '0) |=> busy);

  // R2
  end_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !spi_sck);

  // R10
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 6'h04) |=> $stable(cmd_word));

  // R11
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 6'h38) |=> $stable(spi_cs_n));
endmodule

bind spi_buffered_master spim_checker #(.NUM_CS(NUM_CS), .K_W(K_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cmd_word(cmd_word), .total_bits(total_bits)
);

// File: tb/test_spi_buffered_master.sv
`timescale 1ns/1ps
module test_spi_buffered_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;
  logic [1:0]  spi_cs_n;

  spi_buffered_master i_spi_buffered_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    rises = 0;
  int    last_rise = 0;
  int    meas_period = 0;
  bit    done = 0;
  string cur_req = "R4";
  logic  exp_q[$];
  logic  miso_stream [1024];
  logic [31:0] m_cmd;
  logic [31:0] m_data [8];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop one expected MOSI bit per rising SCK edge
  always @(posedge spi_sck) begin
    logic b;
    #1;
    n_vec++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s: unexpected SCK edge %0d (actual edge, expected none)", cur_req, rises);
    end else begin
      b = exp_q.pop_front();
      if (spi_mosi !== b) begin
        n_bad++;
        $display("FAIL %s: MOSI bit %0d actual %b expected %b", cur_req, rises, spi_mosi, b);
      end
    end
    if (rises == 1) meas_period = cyc - last_rise;
    last_rise = cyc;
    rises++;
    spi_miso = miso_stream[rises];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_read(6'h00, v);
      if (v[16] == 1'b0) return;
    end
    n_vec++; n_bad++;
    $display("FAIL R2: busy never cleared (actual 1 expected 0)");
  endtask

  task automatic run_xfer(input string req, input int c, input int w, input int r,
                          input bit lsb, input int divf, input bit meddle);
    int ce, we_, re, p, idx, k;
    logic [31:0] v;
    ce  = (c > 32) ? 32 : c;
    we_ = (w > 256) ? 256 : w;
    re  = (r > 256) ? 256 : r;
    cur_req = req;
    bus_write(6'h28, (32'(divf) << 16) | (32'(lsb) << 3));
    bus_write(6'h2C, (32'(c) << 24) | (32'(r) << 12) | 32'(w));
    bus_write(6'h04, m_cmd);
    for (int i = 0; i < 1024; i++) miso_stream[i] = 1'b0;
    for (int j = 0; j < ce; j++) begin
      p = ce - 1 - j;
      if (lsb) p = (p & ~7) | (7 - (p & 7));
      exp_q.push_back(m_cmd[p]);
    end
    for (int j = 0; j < we_; j++) begin
      idx = (j / 8) * 8 + (lsb ? (j % 8) : (7 - j % 8));
      exp_q.push_back(m_data[idx / 32][idx % 32]);
    end
    for (int j = 0; j < re; j++) begin
      k = ce + we_ + j;
      miso_stream[k] = ((j * 5 + j / 3) % 3 == 0);
      exp_q.push_back(1'b0);
    end
    rises = 0;
    meas_period = 0;
    spi_miso = miso_stream[0];
    bus_write(6'h00, 32'h100);
    if (meddle) begin
      repeat (20) @(posedge clk);
      bus_write(6'h00, 32'h100);
      bus_write(6'h08, 32'hDEADBEEF);
      bus_write(6'h04, ~m_cmd);
      bus_write(6'h2C, 32'h0);
      bus_write(6'h28, 32'h0);
    end
    wait_idle();
    chk({req, " edge count"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    chk("R3 idle sck", {31'd0, spi_sck}, 32'd0);
    if (ce + we_ + re >= 2) chk("R3 period", 32'(meas_period), 32'(divf + 2));
    for (int j = 0; j < re; j++) begin
      idx = (j / 8) * 8 + (lsb ? (j % 8) : (7 - j % 8));
      m_data[idx / 32][idx % 32] = miso_stream[ce + we_ + j];
    end
    for (int i = 0; i < 8; i++) begin
      bus_read(6'(8 + 4 * i), v);
      chk("R7 R12 buffer", v, m_data[i]);
    end
    if (meddle) begin
      bus_read(6'h04, v);
      chk("R10 cmd kept", v, m_cmd);
      bus_read(6'h2C, v);
      chk("R10 len kept", v, (32'(c) << 24) | (32'(r) << 12) | 32'(w));
      bus_read(6'h28, v);
      chk("R10 ctrl kept", v, (32'(divf) << 16) | (32'(lsb) << 3));
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 sck", {31'd0, spi_sck}, 32'd0);
    chk("R1 mosi", {31'd0, spi_mosi}, 32'd0);
    chk("R1 cs_n", {30'd0, spi_cs_n}, 32'd3);
    bus_read(6'h00, v); chk("R1 busy", v, 32'd0);
    bus_read(6'h2C, v); chk("R1 len", v, 32'd0);
    bus_read(6'h08, v); chk("R1 data", v, 32'd0);

    // R11 select
    bus_write(6'h38, 32'd1);
    chk("R11 cs0 on", {30'd0, spi_cs_n}, 32'd2);

    m_cmd = 32'hA1B2C3D4;
    for (int i = 0; i < 8; i++) begin
      m_data[i] = 32'h0F1E2D3C + 32'(i) * 32'h11223344;
      bus_write(6'(8 + 4 * i), m_data[i]);
    end
    bus_read(6'h14, v); chk("R12 data readback", v, m_data[3]);

    // R2 zero counts: no transaction
    bus_write(6'h2C, 32'h0);
    bus_write(6'h00, 32'h100);
    bus_read(6'h00, v); chk("R2 zero len idle", v, 32'd0);

    run_xfer("R5", 24, 0, 0, 0, 0, 0);
    run_xfer("R6", 0, 40, 0, 0, 1, 0);
    run_xfer("R7", 8, 0, 64, 0, 6, 0);
    run_xfer("R8", 16, 16, 16, 1, 2, 0);
    run_xfer("R4", 40, 300, 0, 0, 0, 0);
    run_xfer("R9", 8, 32, 0, 0, 3, 1);
    run_xfer("R4", 4, 12, 20, 0, 5, 0);

    // R11 select held across transactions, then changed
    chk("R11 cs held", {30'd0, spi_cs_n}, 32'd2);
    bus_write(6'h38, 32'd2);
    chk("R11 cs1 on", {30'd0, spi_cs_n}, 32'd1);
    bus_read(6'h38, v); chk("R12 sel readback", v, 32'd2);
    bus_write(6'h38, 32'd0);
    chk("R11 cs off", {30'd0, spi_cs_n}, 32'd3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule